// File: doc/BRIEF.md
# Packed-BCD Add/Subtract Unit with Decimal-Aware Flags

This block is the add and subtract datapath of a small processor whose status word carries a decimal-mode flag. It takes two operands and a carry input. In binary mode it forms the two's-complement sum or difference. In decimal mode it treats each 4-bit nibble as one packed BCD digit and corrects every digit so that the result is itself valid BCD. In both modes the carry, negative, overflow and zero flags come from the final result. In decimal mode that is the corrected value, never the raw binary sum.

The block owns the decimal-mode flag. Software-style writes load it. An interrupt-entry pulse clears it one edge later, so the copy the core pushes in that cycle still shows the old value. Reset also clears it. A binary operation finishes in a single cycle. A decimal operation holds the unit for one extra cycle, and `extra_cycle` reports that stall so the surrounding sequencer can wait. The digit count is a parameter, and the default is two digits (8 bits).

Top module: `dec_addsub_unit`

## Requirements
- R1: Binary mode (decimal flag 0): an add gives `result = a + b + carry_in` modulo 2^W, and `flag_c` is the carry out of bit W-1. A subtract gives `result = a - b - (1 - carry_in)` modulo 2^W, and `flag_c` = 1 means no borrow occurred.
- R2: In every mode, `flag_n` is result bit W-1 and `flag_z` is 1 exactly when the result is zero. `flag_v` uses the signs of the operands and the result. For an add it is 1 when a and b have the same sign and the result sign differs from a. For a subtract it is 1 when a and b have different signs and the result sign differs from a.
- R3: Decimal mode add, with each nibble one BCD digit and the least significant digit in bits 3:0: the result is the BCD encoding of (a + b + carry_in) modulo 10^NDIG. `flag_c` is 1 when that sum exceeds 10^NDIG - 1 (99 by default).
- R4: Decimal mode subtract: the result is the BCD encoding of (a - b - (1 - carry_in)) modulo 10^NDIG. `flag_c` is 1 when the difference is not negative.
- R5: In decimal mode, N, V and Z follow the rules of R2 applied to the BCD-corrected result. The intermediate binary sum does not affect them. For example, 58 + 46 gives result 0x04 with N = 0 and V = 0, and 99 + 01 gives 0x00 with Z = 1.
- R6: A binary operation accepted at a clock edge (`op_valid` high and `extra_cycle` low) shows its result and a one-cycle `res_valid` pulse right after that edge, and `extra_cycle` stays low. Without a new result, `result` and the flags hold their values.
- R7: A decimal operation raises `extra_cycle` for the one cycle after acceptance, with `res_valid` low. The result and `res_valid` appear one cycle later, with `extra_cycle` low again.
- R8: `op_valid` is ignored while `extra_cycle` is high. The pending decimal result is delivered unchanged, and no second result follows.
- R9: Reset clears the decimal flag, `result`, all flags, `res_valid` and `extra_cycle`, so arithmetic restarts in binary mode.
- R10: `dflag_wr` loads `dflag_wdata` into the decimal flag at the next edge. An operation accepted in the same cycle uses the flag value from before the write.
- R11: During an `irq_entry` cycle `dec_flag` still shows the old value, which is the copy to be pushed. After the edge it reads 0. `irq_entry` wins over a simultaneous `dflag_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Start an operation this cycle |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| op_a | input | 4*NDIG | First operand |
| op_b | input | 4*NDIG | Second operand |
| carry_in | input | 1 | Carry in (inverted borrow for subtract) |
| dflag_wr | input | 1 | Load the decimal flag |
| dflag_wdata | input | 1 | Value for the decimal flag |
| irq_entry | input | 1 | Interrupt entry; status is pushed this cycle |
| result | output | 4*NDIG | Registered result |
| flag_c | output | 1 | Carry / no-borrow |
| flag_n | output | 1 | Negative |
| flag_v | output | 1 | Signed overflow |
| flag_z | output | 1 | Zero |
| res_valid | output | 1 | One-cycle pulse when a new result appears |
| extra_cycle | output | 1 | Decimal stall cycle in progress |
| dec_flag | output | 1 | Current decimal-mode flag |

## Verification
The interesting overlap is an interrupt entry that arrives in the same cycle as a decimal operation is accepted. The bench sets the decimal flag, then asserts `irq_entry` and `op_valid` together. It checks that `dec_flag` still reads 1 before the edge and 0 after it. It also checks that the operation still takes the decimal path, with its stall cycle and a BCD-corrected result. A second overlap issues a flag write together with an operation and confirms that the operation runs in the old mode.

// File: rtl/dec_addsub_pkg.sv
package dec_addsub_pkg;

   typedef struct packed {
      logic c;
      logic n;
      logic v;
      logic z;
   } alu_flags_t;

   typedef enum logic {
      ARITH_BIN = 1'b0,
      ARITH_DEC = 1'b1
   } arith_mode_e;

   // signed overflow judged on final result and operand signs
   function automatic logic ovf_rule(input logic sub, input logic a_msb,
                                     input logic b_msb, input logic r_msb);
      logic signs_match;
      signs_match = sub ? (a_msb != b_msb) : (a_msb == b_msb);
      return signs_match && (r_msb != a_msb);
   endfunction

endpackage

// File: rtl/bcd_digit_slice.sv
module bcd_digit_slice (
   input  logic [3:0] dig_a,
   input  logic [3:0] dig_b,
   input  logic       sub,
   input  logic       cy_in,   // carry (add) or borrow (sub) from lower digit
   output logic [3:0] dig_out,
   output logic       cy_out   // carry (add) or borrow (sub) to upper digit
);
   logic [4:0] raw;

   always_comb begin
      if (!sub) begin
         raw = {1'b0, dig_a} + {1'b0, dig_b} + {4'b0000, cy_in};
         if (raw > 5'd9) begin
            dig_out = 4'(raw + 5'd6);
            cy_out  = 1'b1;
         end else begin
            dig_out = raw[3:0];
            cy_out  = 1'b0;
         end
      end else begin
         raw = {1'b0, dig_a} - {1'b0, dig_b} - {4'b0000, cy_in};
         if (raw[4]) begin
            // negative digit difference: wrap by ten, borrow upward
            dig_out = 4'(raw + 5'd10);
            cy_out  = 1'b1;
         end else begin
            dig_out = raw[3:0];
            cy_out  = 1'b0;
         end
      end
   end

endmodule

// File: rtl/bcd_chain.sv
module bcd_chain #(
   parameter  int NDIG = 2,
   localparam int W    = 4 * NDIG
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   input  logic         cin,    // processor carry: for sub, 1 = no borrow
   output logic [W-1:0] sum,
   output logic         cout
);
   logic [NDIG:0] link;

   assign link[0] = sub ? ~cin : cin;

   for (genvar g = 0; g < NDIG; g++) begin : g_dig
      bcd_digit_slice slice_i (
         .dig_a   (a[4*g +: 4]),
         .dig_b   (b[4*g +: 4]),
         .sub     (sub),
         .cy_in   (link[g]),
         .dig_out (sum[4*g +: 4]),
         .cy_out  (link[g+1])
      );
   end

   assign cout = sub ? ~link[NDIG] : link[NDIG];

endmodule

// File: rtl/bin_addsub.sv
module bin_addsub #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);
   logic [W-1:0] b_eff;
   logic [W:0]   total;

   assign b_eff = sub ? ~b : b;
   assign total = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
   assign sum   = total[W-1:0];
   assign cout  = total[W];

endmodule

// File: rtl/flag_gen.sv
module flag_gen
   import dec_addsub_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] res,
   input  logic         a_msb,
   input  logic         b_msb,
   input  logic         sub,
   input  logic         cout,
   output alu_flags_t   flags
);
   always_comb begin
      flags.c = cout;
      flags.n = res[W-1];
      flags.z = (res == '0);
      flags.v = ovf_rule(sub, a_msb, b_msb, res[W-1]);
   end

endmodule

// File: rtl/dflag_ctrl.sv
module dflag_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  logic wdata,
   input  logic irq_entry,
   output logic dflag
);
   // interrupt entry clears after the push cycle and outranks writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         dflag <= 1'b0;
      else if (irq_entry) dflag <= 1'b0;
      else if (wr)        dflag <= wdata;
   end

endmodule

// File: rtl/dec_addsub_unit.sv
module dec_addsub_unit
   import dec_addsub_pkg::*;
#(
   parameter  int NDIG = 2,
   localparam int W    = 4 * NDIG
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         op_valid,
   input  logic         op_sub,
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   input  logic         carry_in,
   input  logic         dflag_wr,
   input  logic         dflag_wdata,
   input  logic         irq_entry,
   output logic [W-1:0] result,
   output logic         flag_c,
   output logic         flag_n,
   output logic         flag_v,
   output logic         flag_z,
   output logic         res_valid,
   output logic         extra_cycle,
   output logic         dec_flag
);
   if (NDIG < 1) begin : g_bad_ndig_low
      $error("dec_addsub_unit: NDIG must be at least 1");
   end
   if (NDIG > 16) begin : g_bad_ndig_high
      $error("dec_addsub_unit: NDIG above 16 is not supported");
   end

   // ---------------- decimal flag ----------------
   dflag_ctrl dflag_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (dflag_wr),
      .wdata     (dflag_wdata),
      .irq_entry (irq_entry),
      .dflag     (dec_flag)
   );

   // ---------------- binary path (same cycle) ----------------
   logic [W-1:0] bin_sum;
   logic         bin_cout;
   alu_flags_t   bin_flags;

   bin_addsub #(.W(W)) bin_i (
      .a    (op_a),
      .b    (op_b),
      .sub  (op_sub),
      .cin  (carry_in),
      .sum  (bin_sum),
      .cout (bin_cout)
   );

   flag_gen #(.W(W)) bin_flag_i (
      .res   (bin_sum),
      .a_msb (op_a[W-1]),
      .b_msb (op_b[W-1]),
      .sub   (op_sub),
      .cout  (bin_cout),
      .flags (bin_flags)
   );

   // ---------------- decimal path (stall cycle) ----------------
   logic [W-1:0] a_q, b_q;
   logic         sub_q, cin_q, busy_q;
   logic [W-1:0] dec_sum;
   logic         dec_cout;
   alu_flags_t   dec_flags;

   bcd_chain #(.NDIG(NDIG)) bcd_i (
      .a    (a_q),
      .b    (b_q),
      .sub  (sub_q),
      .cin  (cin_q),
      .sum  (dec_sum),
      .cout (dec_cout)
   );

   flag_gen #(.W(W)) dec_flag_i (
      .res   (dec_sum),
      .a_msb (a_q[W-1]),
      .b_msb (b_q[W-1]),
      .sub   (sub_q),
      .cout  (dec_cout),
      .flags (dec_flags)
   );

   // ---------------- sequencing ----------------
   arith_mode_e  mode;
   logic         accept;
   logic [W-1:0] result_q;
   alu_flags_t   flags_q;
   logic         valid_q;

   assign mode   = arith_mode_e'(dec_flag);
   assign accept = op_valid && !busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_q <= '0;
         flags_q  <= '0;
         valid_q  <= 1'b0;
         busy_q   <= 1'b0;
         a_q      <= '0;
         b_q      <= '0;
         sub_q    <= 1'b0;
         cin_q    <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (busy_q) begin
            result_q <= dec_sum;
            flags_q  <= dec_flags;
            valid_q  <= 1'b1;
            busy_q   <= 1'b0;
         end else if (accept) begin
            if (mode == ARITH_DEC) begin
               busy_q <= 1'b1;
               a_q    <= op_a;
               b_q    <= op_b;
               sub_q  <= op_sub;
               cin_q  <= carry_in;
            end else begin
               result_q <= bin_sum;
               flags_q  <= bin_flags;
               valid_q  <= 1'b1;
            end
         end
      end
   end

   assign result      = result_q;
   assign flag_c      = flags_q.c;
   assign flag_n      = flags_q.n;
   assign flag_v      = flags_q.v;
   assign flag_z      = flags_q.z;
   assign res_valid   = valid_q;
   assign extra_cycle = busy_q;

endmodule

// File: rtl/dec_addsub_unit_chk.sv
module dec_addsub_unit_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         op_valid,
   input logic         dflag_wr,
   input logic         dflag_wdata,
   input logic         irq_entry,
   input logic [W-1:0] result,
   input logic         flag_n,
   input logic         flag_z,
   input logic         res_valid,
   input logic         extra_cycle,
   input logic         dec_flag
);
   p_bin_onecycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !extra_cycle && !dec_flag) |=> (res_valid && !extra_cycle));

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_valid && !extra_cycle) |=> $stable(result));

   p_dec_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !extra_cycle && dec_flag) |=> (extra_cycle && !res_valid));

   p_dec_finish_r7: assert property (@(posedge clk) disable iff (!rst_n)
      extra_cycle |=> (res_valid && !extra_cycle));

   p_zero_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (flag_z == (result == '0)));   // also covers R2

   p_neg_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (flag_n == result[W-1]));      // also covers R2

   p_dflag_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (dflag_wr && !irq_entry) |=> (dec_flag == $past(dflag_wdata)));

   p_irq_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_entry |=> !dec_flag);

endmodule

bind dec_addsub_unit dec_addsub_unit_chk #(.W(W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .op_valid    (op_valid),
   .dflag_wr    (dflag_wr),
   .dflag_wdata (dflag_wdata),
   .irq_entry   (irq_entry),
   .result      (result),
   .flag_n      (flag_n),
   .flag_z      (flag_z),
   .res_valid   (res_valid),
   .extra_cycle (extra_cycle),
   .dec_flag    (dec_flag)
);

// File: tb/dec_addsub_unit_tb_top.sv
module dec_addsub_unit_tb_top;
   localparam int NV = 17;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0, op_sub = 1'b0, carry_in = 1'b0;
   logic [7:0] op_a = '0, op_b = '0;
   logic       dflag_wr = 1'b0, dflag_wdata = 1'b0, irq_entry = 1'b0;
   logic [7:0] result;
   logic       flag_c, flag_n, flag_v, flag_z, res_valid, extra_cycle, dec_flag;

   int n_checks = 0;
   int n_fail   = 0;

   always #10 clk = ~clk;   // 50 MHz

   dec_addsub_unit #(.NDIG(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sub(op_sub),
      .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .dflag_wr(dflag_wr),
      .dflag_wdata(dflag_wdata), .irq_entry(irq_entry), .result(result),
      .flag_c(flag_c), .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z),
      .res_valid(res_valid), .extra_cycle(extra_cycle), .dec_flag(dec_flag)
   );

   // {dec, sub, cin, a, b, expected result, expected carry}
   localparam logic [27:0] VEC [NV] = '{
      {1'b0, 1'b0, 1'b0, 8'h12, 8'h34, 8'h46, 1'b0},
      {1'b0, 1'b0, 1'b0, 8'hFF, 8'h01, 8'h00, 1'b1},
      {1'b0, 1'b0, 1'b0, 8'h7F, 8'h01, 8'h80, 1'b0},
      {1'b0, 1'b1, 1'b1, 8'h50, 8'h30, 8'h20, 1'b1},
      {1'b0, 1'b1, 1'b1, 8'h00, 8'h01, 8'hFF, 1'b0},
      {1'b0, 1'b1, 1'b1, 8'h80, 8'h01, 8'h7F, 1'b1},
      {1'b0, 1'b0, 1'b1, 8'h80, 8'h80, 8'h01, 1'b1},
      {1'b1, 1'b0, 1'b0, 8'h45, 8'h38, 8'h83, 1'b0},
      {1'b1, 1'b0, 1'b0, 8'h58, 8'h46, 8'h04, 1'b1},
      {1'b1, 1'b0, 1'b0, 8'h99, 8'h01, 8'h00, 1'b1},
      {1'b1, 1'b0, 1'b1, 8'h25, 8'h49, 8'h75, 1'b0},
      {1'b1, 1'b0, 1'b0, 8'h40, 8'h40, 8'h80, 1'b0},
      {1'b1, 1'b1, 1'b1, 8'h00, 8'h01, 8'h99, 1'b0},
      {1'b1, 1'b1, 1'b1, 8'h50, 8'h25, 8'h25, 1'b1},
      {1'b1, 1'b1, 1'b0, 8'h46, 8'h12, 8'h33, 1'b1},
      {1'b1, 1'b1, 1'b1, 8'h10, 8'h10, 8'h00, 1'b1},
      {1'b1, 1'b1, 1'b0, 8'h12, 8'h21, 8'h90, 1'b0}
   };

   task automatic check(input logic ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic exp_v(input logic sub, input logic [7:0] a,
                                  input logic [7:0] b, input logic [7:0] r);
      if (sub) return (a[7] != b[7]) && (r[7] != a[7]);
      else     return (a[7] == b[7]) && (r[7] != a[7]);
   endfunction

   task automatic set_dflag(input logic val);
      @(negedge clk);
      dflag_wr = 1'b1; dflag_wdata = val;
      @(negedge clk);
      dflag_wr = 1'b0;
   endtask

   task automatic start_op(input logic sub, input logic cin,
                           input logic [7:0] a, input logic [7:0] b);
      op_valid = 1'b1; op_sub = sub; carry_in = cin; op_a = a; op_b = b;
   endtask

   task automatic check_out(input string tag, input logic sub, input logic [7:0] a,
                            input logic [7:0] b, input logic [7:0] er, input logic ec);
      logic [3:0] got, exp;
      check(result == er, tag, "result", 32'(result), 32'(er));
      got = {flag_c, flag_n, flag_v, flag_z};
      exp = {ec, er[7], exp_v(sub, a, b, er), (er == 8'h00)};
      check(got == exp, tag, "flags CNVZ", 32'(got), 32'(exp));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      string tag;
      repeat (3) @(negedge clk);
      // R9 reset state
      check(dec_flag == 1'b0 && res_valid == 1'b0 && extra_cycle == 1'b0,
            "R9", "dflag/valid/stall in reset", {dec_flag, res_valid, extra_cycle}, 0);
      check(result == 8'h00 && {flag_c, flag_n, flag_v, flag_z} == 4'h0,
            "R9", "result/flags in reset", {result, flag_c, flag_n, flag_v, flag_z}, 0);
      rst_n = 1'b1;

      // table walk: R1 R2 binary, R3 R4 R5 decimal, R6 R7 latency
      for (int i = 0; i < NV; i++) begin
         logic dec, sub, cin, ec;
         logic [7:0] a, b, er;
         {dec, sub, cin, a, b, er, ec} = VEC[i];
         tag = dec ? (sub ? "R4/R5" : "R3/R5") : (sub ? "R1/R2" : "R1/R2");
         set_dflag(dec);
         start_op(sub, cin, a, b);
         @(negedge clk);
         op_valid = 1'b0;
         if (dec) begin
            check(extra_cycle && !res_valid, "R7", "stall cycle", {extra_cycle, res_valid}, 2'b10);
            @(negedge clk);
            check(res_valid && !extra_cycle, "R7", "decimal result cycle", {res_valid, extra_cycle}, 2'b10);
         end else begin
            check(res_valid && !extra_cycle, "R6", "binary result cycle", {res_valid, extra_cycle}, 2'b10);
         end
         check_out(tag, sub, a, b, er, ec);
      end

      // R6 hold: no new op, result stays
      @(negedge clk);
      check(!res_valid && result == 8'h90, "R6", "hold after result", {res_valid, result}, 9'h090);

      // R10: write and op in same cycle -> op uses old (binary) mode
      set_dflag(1'b0);
      dflag_wr = 1'b1; dflag_wdata = 1'b1;
      start_op(1'b0, 1'b0, 8'h58, 8'h46);
      @(negedge clk);
      dflag_wr = 1'b0; op_valid = 1'b0;
      check(res_valid && !extra_cycle && result == 8'h9E, "R10", "op uses pre-write mode",
            {res_valid, extra_cycle, result}, {2'b10, 8'h9E});
      check(dec_flag == 1'b1, "R10", "flag loaded", dec_flag, 1);

      // R11: interrupt entry with decimal op in the same cycle
      @(negedge clk);
      irq_entry = 1'b1;
      start_op(1'b0, 1'b0, 8'h58, 8'h46);
      #1;
      check(dec_flag == 1'b1, "R11", "pushed copy keeps old flag", dec_flag, 1);
      @(negedge clk);
      irq_entry = 1'b0; op_valid = 1'b0;
      check(dec_flag == 1'b0, "R11", "flag cleared after entry", dec_flag, 0);
      check(extra_cycle == 1'b1, "R11", "op still decimal", extra_cycle, 1);
      @(negedge clk);
      check_out("R11", 1'b0, 8'h58, 8'h46, 8'h04, 1'b1);

      // R11: irq outranks a simultaneous write of 1
      @(negedge clk);
      irq_entry = 1'b1; dflag_wr = 1'b1; dflag_wdata = 1'b1;
      @(negedge clk);
      irq_entry = 1'b0; dflag_wr = 1'b0;
      check(dec_flag == 1'b0, "R11", "irq beats write", dec_flag, 0);

      // R8: op during stall ignored
      set_dflag(1'b1);
      start_op(1'b0, 1'b1, 8'h25, 8'h49);
      @(negedge clk);
      start_op(1'b0, 1'b0, 8'h01, 8'h01);
      @(negedge clk);
      op_valid = 1'b0;
      check(res_valid && result == 8'h75, "R8", "pending result unchanged",
            {res_valid, result}, 9'h175);
      @(negedge clk);
      check(!res_valid && !extra_cycle && result == 8'h75, "R8", "no second result",
            {res_valid, extra_cycle, result}, 10'h075);

      // R9: reset clears decimal flag
      check(dec_flag == 1'b1, "R9", "flag set before reset", dec_flag, 1);
      rst_n = 1'b0;
      @(negedge clk);
      check(dec_flag == 1'b0 && result == 8'h00, "R9", "reset clears flag/result",
            {dec_flag, result}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      start_op(1'b0, 1'b0, 8'h09, 8'h01);
      @(negedge clk);
      op_valid = 1'b0;
      check(res_valid && !extra_cycle && result == 8'h0A, "R9", "binary after reset",
            {res_valid, extra_cycle, result}, {2'b10, 8'h0A});

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule